// File: doc/BRIEF.md
# Serial Memory Sleep Entry and Wake Controller

This block decides when a serial memory slave drops into one of its two low-power states, deep sleep or hibernate, and when it may come back. The command shifter hands it each completed opcode together with a pulse for every serial-clock edge. The block also sees the chip-select level, already brought into the system clock domain. A low-power opcode only arms the block. The state change is made on the chip-select rise that directly follows the opcode. If any serial-clock edge shows up first, the request is dropped.

While asleep, the block withdraws the enable of the serial interface and forces the data output to high impedance. Clock pulses and opcodes have no effect in this state. A low pulse on chip select that is long enough starts the wake-up. After a recovery time that is counted in system-clock cycles and that differs between the two states, the interface is enabled again. On that return the block pulses a request to clear the write-enable latch.

A chip-select fall that arrives while recovery is still running is a protocol violation. It is recorded in a sticky flag and does not restart the timer. A synchronous reset brings the block straight back to normal operation with no recovery delay.

Top module: `lp_power_ctrl`

## Requirements
- R1: After reset, if_enable=1, so_hiz_force=0, recovering=0, wel_clear=0 and violation=0.
- R2: op_valid with op_code 8'hBA (deep sleep) or 8'hB9 (hibernate), sampled while cs_n=0, arms the block and leaves the outputs unchanged. The first cs_n rise sampled after that, with no sck_edge sampled from the opcode cycle up to and including the rise cycle, puts the block to sleep. In the cycle after that rise, if_enable=0 and so_hiz_force=1.
- R3: Any other op_code value (for example 8'h03 or 8'hBB) does not arm the block, and a later cs_n rise leaves if_enable=1.
- R4: An sck_edge sampled while armed cancels the request, even when it falls in the same cycle as the cs_n rise. if_enable then stays 1.
- R5: While asleep, sck_edge, op_valid and op_code are ignored: if_enable stays 0, so_hiz_force stays 1 and recovering stays 0.
- R6: Wake-up needs cs_n low for at least MIN_LOW consecutive samples, counting the fall sample. A shorter pulse returns the block to sleep: recovering drops back to 0 and if_enable stays 0.
- R7: From the first clock edge that samples cs_n low (edge P0), recovering=1 from the next cycle on. For deep sleep, if_enable is 0 after edge P0+REC_DPD-1 and 1 after edge P0+REC_DPD.
- R8: The same timing holds for hibernate with REC_HIB in place of REC_DPD.
- R9: On return to normal, wel_clear is 1 for exactly one cycle: the cycle in which if_enable first reads 1.
- R10: A cs_n fall sampled during recovery, before edge P0+REC, sets violation, which stays 1 until reset. The wake time is not changed. A fall sampled on edge P0+REC itself is not a violation.
- R11: rst=1 during sleep or recovery makes if_enable=1 and recovering=0 in the next cycle, with no wel_clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, forces normal mode |
| cs_n | input | 1 | Chip-select level, active low, synchronous to clk |
| sck_edge | input | 1 | One-cycle pulse per serial-clock edge seen by the front end |
| op_valid | input | 1 | One-cycle pulse: op_code holds a complete opcode |
| op_code | input | 8 | Decoded opcode byte |
| if_enable | output | 1 | Serial interface may operate |
| so_hiz_force | output | 1 | Force the serial data output to high impedance |
| recovering | output | 1 | Wake pulse being qualified or recovery running |
| wel_clear | output | 1 | One-cycle request to clear the write-enable latch |
| violation | output | 1 | Sticky: chip select fell during recovery |

## Verification
A serial-clock edge and the chip-select rise can arrive in the same cycle while the block is armed. The bench drives sck_edge and the cs_n rise at the same sampling edge and expects if_enable to remain 1, because cancellation must take priority over entry. A second collision is placed at the end of recovery: a chip-select fall is timed to hit the very edge on which recovery completes. The bench expects a normal wake with the wel_clear pulse and no violation.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    LP_NORMAL,
    LP_ARMED,
    LP_SLEEP,
    LP_WAKE,
    LP_RECOVER
  } lp_state_t;

  typedef enum logic {
    SLP_DEEP,
    SLP_HIB
  } lp_kind_t;

  localparam logic [7:0] OP_DEEP = 8'hBA;
  localparam logic [7:0] OP_HIB  = 8'hB9;
endpackage

// File: rtl/lp_cs_edge.sv
module lp_cs_edge (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  output logic cs_fall,
  output logic cs_rise
);
  logic cs_d;

  always_ff @(posedge clk) begin
    if (rst) cs_d <= 1'b1;
    else     cs_d <= cs_n;
  end

  assign cs_fall = cs_d & ~cs_n;
  assign cs_rise = ~cs_d & cs_n;
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (clear) count <= CW'(1);
    else if (run)   count <= count + CW'(1);
  end
endmodule

// File: rtl/lp_power_ctrl.sv
module lp_power_ctrl #(
  parameter int MIN_LOW = 10,
  parameter int REC_DPD = 1000,
  parameter int REC_HIB = 45000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck_edge,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  output logic       if_enable,
  output logic       so_hiz_force,
  output logic       recovering,
  output logic       wel_clear,
  output logic       violation
);
  import lp_pkg::*;

  localparam int REC_MAX = (REC_DPD > REC_HIB) ? REC_DPD : REC_HIB;
  localparam int CW      = $clog2(REC_MAX + 2);

  generate
    if (MIN_LOW < 2 || REC_DPD <= MIN_LOW || REC_HIB <= MIN_LOW) begin : g_bad_cfg
      $error("lp_power_ctrl: need MIN_LOW >= 2 and both recovery times above MIN_LOW");
    end
  endgenerate

  lp_state_t     state, state_nx;
  lp_kind_t      kind, kind_nx;
  logic          cs_fall, cs_rise;
  logic          tmr_clr, tmr_run;
  logic [CW-1:0] tmr_cnt;
  logic [CW-1:0] rec_lim;
  logic          viol_set, wake_done;
  logic          lp_op;

  lp_cs_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .cs_fall (cs_fall),
    .cs_rise (cs_rise)
  );

  lp_wake_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clr),
    .run   (tmr_run),
    .count (tmr_cnt)
  );

  assign lp_op   = (op_code == OP_DEEP) || (op_code == OP_HIB);
  assign rec_lim = (kind == SLP_HIB) ? CW'(REC_HIB) : CW'(REC_DPD);

  always_comb begin
    state_nx  = state;
    kind_nx   = kind;
    tmr_clr   = 1'b0;
    tmr_run   = 1'b0;
    viol_set  = 1'b0;
    wake_done = 1'b0;
    case (state)
      LP_NORMAL: begin
        if (op_valid && !cs_n && lp_op) begin
          state_nx = LP_ARMED;
          kind_nx  = (op_code == OP_HIB) ? SLP_HIB : SLP_DEEP;
        end
      end
      LP_ARMED: begin
        // a clock edge cancels, also when it meets the rise
        if (sck_edge)     state_nx = LP_NORMAL;
        else if (cs_rise) state_nx = LP_SLEEP;
      end
      LP_SLEEP: begin
        if (cs_fall) begin
          state_nx = LP_WAKE;
          tmr_clr  = 1'b1;
        end
      end
      LP_WAKE: begin
        tmr_run = 1'b1;
        if (tmr_cnt >= CW'(MIN_LOW)) begin
          state_nx = LP_RECOVER;
        end else if (cs_n) begin
          state_nx = LP_SLEEP;
          tmr_run  = 1'b0;
        end
      end
      LP_RECOVER: begin
        if (tmr_cnt >= rec_lim) begin
          state_nx  = LP_NORMAL;
          wake_done = 1'b1;
        end else begin
          tmr_run  = 1'b1;
          viol_set = cs_fall;
        end
      end
      default: state_nx = LP_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LP_NORMAL;
      kind  <= SLP_DEEP;
    end else begin
      state <= state_nx;
      kind  <= kind_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_enable    <= 1'b1;
      so_hiz_force <= 1'b0;
      recovering   <= 1'b0;
      wel_clear    <= 1'b0;
      violation    <= 1'b0;
    end else begin
      if_enable    <= (state_nx == LP_NORMAL) || (state_nx == LP_ARMED);
      so_hiz_force <= !((state_nx == LP_NORMAL) || (state_nx == LP_ARMED));
      recovering   <= (state_nx == LP_WAKE) || (state_nx == LP_RECOVER);
      wel_clear    <= wake_done;
      violation    <= violation | viol_set;
    end
  end
endmodule

// File: rtl/lp_power_ctrl_chk.sv
module lp_power_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic if_enable,
  input logic recovering,
  input logic wel_clear,
  input logic violation
);
  // R2: sleep begins only right after a sampled chip-select rise
  assert_entry_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(if_enable) |-> ($past(cs_n) && !$past(cs_n, 2)));

  // R9: latch clear follows a recovery
  assert_clear_after_recover_R9: assert property (@(posedge clk) disable iff (rst)
    wel_clear |-> $past(recovering));

  // R9: every return to normal outside reset carries the clear pulse
  assert_wake_clears_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(if_enable) && !$past(rst)) |-> wel_clear);

  // R9: the clear pulse lasts one cycle
  assert_clear_single_R9: assert property (@(posedge clk) disable iff (rst)
    wel_clear |=> !wel_clear);

  // R10: violation is sticky
  assert_violation_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);
endmodule

bind lp_power_ctrl lp_power_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .if_enable  (if_enable),
  .recovering (recovering),
  .wel_clear  (wel_clear),
  .violation  (violation)
);

// File: tb/sim_lp_power_ctrl.sv
module sim_lp_power_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOW    = 5;
  localparam int REC_DPD    = 40;
  localparam int REC_HIB    = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sck_edge = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic       if_enable, so_hiz_force, recovering, wel_clear, violation;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_power_ctrl #(.MIN_LOW(MIN_LOW), .REC_DPD(REC_DPD), .REC_HIB(REC_HIB)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck_edge(sck_edge),
    .op_valid(op_valid), .op_code(op_code), .if_enable(if_enable),
    .so_hiz_force(so_hiz_force), .recovering(recovering),
    .wel_clear(wel_clear), .violation(violation)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // issue an opcode inside a frame, then raise chip select
  task automatic send_op(input logic [7:0] op, input logic sck_between, input logic sck_at_rise,
                         input logic exp_sleep, input string req);
    cs_n = 1'b0;
    @(negedge clk); op_valid = 1'b1; op_code = op;
    @(negedge clk); op_valid = 1'b0;
    chk(req, "if_enable while armed", if_enable, 1'b1);
    if (sck_between) begin
      sck_edge = 1'b1;
      @(negedge clk); sck_edge = 1'b0;
    end
    cs_n = 1'b1; sck_edge = sck_at_rise;
    @(negedge clk); sck_edge = 1'b0;
    chk(req, "if_enable after rise", if_enable, !exp_sleep);
    chk(req, "so_hiz_force after rise", so_hiz_force, exp_sleep);
  endtask

  task automatic do_wake(input int rec_len, input int refall, input logic exp_viol, input string req);
    cs_n = 1'b0;
    for (int j = 1; j <= rec_len + 2; j++) begin
      @(negedge clk);
      if (j == 1) chk(req, "recovering after fall", recovering, 1'b1);
      if (j == rec_len) chk(req, "if_enable one cycle before wake", if_enable, 1'b0);
      if (j == rec_len + 1) begin
        chk(req, "if_enable at wake", if_enable, 1'b1);
        chk("R9", "wel_clear at wake", wel_clear, 1'b1);
      end
      if (j == rec_len + 2) chk("R9", "wel_clear after wake", wel_clear, 1'b0);
      if (j == MIN_LOW) cs_n = 1'b1;
      if (refall != 0 && j == refall) cs_n = 1'b0;
    end
    chk("R10", "violation flag", violation, exp_viol);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "if_enable", if_enable, 1'b1);
    chk("R1", "so_hiz_force", so_hiz_force, 1'b0);
    chk("R1", "recovering", recovering, 1'b0);
    chk("R1", "wel_clear", wel_clear, 1'b0);
    chk("R1", "violation", violation, 1'b0);
  endtask

  task automatic t_deep();
    send_op(8'hBA, 1'b0, 1'b0, 1'b1, "R2");
    do_wake(REC_DPD, 0, 1'b0, "R7");
  endtask

  task automatic t_hib();
    send_op(8'hB9, 1'b0, 1'b0, 1'b1, "R2");
    do_wake(REC_HIB, 0, 1'b0, "R8");
  endtask

  task automatic t_bad_op();
    send_op(8'h03, 1'b0, 1'b0, 1'b0, "R3");
    send_op(8'hBB, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_cancel();
    send_op(8'hBA, 1'b1, 1'b0, 1'b0, "R4");
    send_op(8'hB9, 1'b0, 1'b1, 1'b0, "R4");
  endtask

  task automatic t_ignore_and_short();
    send_op(8'hBA, 1'b0, 1'b0, 1'b1, "R5");
    for (int k = 0; k < 4; k++) begin
      sck_edge = 1'b1; op_valid = 1'b1; op_code = 8'hB9;
      @(negedge clk);
    end
    sck_edge = 1'b0; op_valid = 1'b0;
    @(negedge clk);
    chk("R5", "if_enable while asleep", if_enable, 1'b0);
    chk("R5", "so_hiz_force while asleep", so_hiz_force, 1'b1);
    chk("R5", "recovering while asleep", recovering, 1'b0);
    // short wake pulse: MIN_LOW-1 low samples
    cs_n = 1'b0;
    for (int j = 1; j <= MIN_LOW; j++) begin
      @(negedge clk);
      if (j == MIN_LOW - 1) cs_n = 1'b1;
    end
    chk("R6", "recovering after short pulse", recovering, 1'b0);
    chk("R6", "if_enable after short pulse", if_enable, 1'b0);
    repeat (REC_DPD + 2) @(negedge clk);
    chk("R6", "still asleep later", if_enable, 1'b0);
    do_wake(REC_DPD, 0, 1'b0, "R7");
  endtask

  task automatic t_violation();
    send_op(8'hBA, 1'b0, 1'b0, 1'b1, "R10");
    do_wake(REC_DPD, MIN_LOW + 2, 1'b1, "R10");
    repeat (3) @(negedge clk);
    chk("R10", "violation stays set", violation, 1'b1);
    do_reset();
    chk("R10", "violation cleared by reset", violation, 1'b0);
  endtask

  task automatic t_fall_at_end();
    send_op(8'hB9, 1'b0, 1'b0, 1'b1, "R10");
    do_wake(REC_HIB, REC_HIB, 1'b0, "R10");
  endtask

  task automatic t_reset_asleep();
    send_op(8'hBA, 1'b0, 1'b0, 1'b1, "R11");
    cs_n = 1'b0;
    repeat (MIN_LOW + 3) @(negedge clk);
    cs_n = 1'b1;
    chk("R11", "recovering before reset", recovering, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "if_enable after reset", if_enable, 1'b1);
    chk("R11", "recovering after reset", recovering, 1'b0);
    chk("R11", "wel_clear after reset", wel_clear, 1'b0);
    @(negedge clk);
    chk("R11", "wel_clear one cycle later", wel_clear, 1'b0);
    repeat (REC_DPD) @(negedge clk);
    chk("R11", "if_enable stays high", if_enable, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_deep();
    t_hib();
    t_bad_op();
    t_cancel();
    t_ignore_and_short();
    t_violation();
    t_fall_at_end();
    t_reset_asleep();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule